// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block collects per-port event indications and funnels them through a three-tier tree onto a single active-low interrupt pin. Every port owns two first-tier registers, one for transmit-side events and one for receive-side events. Each bit latches when its raw status input changes. A bit configured as single-event latches only on assertion. A bit configured as dual-event latches on both assertion and deassertion, so software is told when a condition is lost and again when it recovers. Reading a first-tier register returns its contents and clears it.

Each port has a second-tier summary with four bits: transmit-any, receive-any, a one-second interrupt level and an external interrupt level. A global third-tier summary holds one bit per port. Every tier has its own enable register, and a pin-enable bit in a general control register gates the final output. Software reaches all of this through a synchronous single-cycle register port. Read data is registered and appears on the cycle after the request.

Address layout: bit 7 selects the global bank. In the port bank, bits 6:3 give the port number and bits 2:0 the register: 0 transmit events, 1 receive events, 2 transmit enables, 3 receive enables, 4 port summary, 5 summary enables. In the global bank, bits 2:0 select 0 port summary, 1 port enables, 2 general control.

Top module: `irq_tree_ctrl`

## Requirements
- R1: During synchronous reset all latched bits, all enables and the read data clear to zero, and `irq_n` is driven high.
- R2: A single-event bit (TX_DUAL_MASK/RX_DUAL_MASK bit = 0; default TX bits 7:4 and RX bits 6:4) latches only when its raw input goes from 0 to 1. A 1-to-0 change does not set it.
- R3: A dual-event bit (mask bit = 1; default TX bits 3:0, RX bits 3:0 and 7) latches on both the 0-to-1 and the 1-to-0 change of its raw input.
- R4: A read of a transmit-event (offset 0) or receive-event (offset 1) register returns its current contents on `bus_rdata` one cycle later and clears that register.
- R5: An event arriving in the same cycle as the clearing read is not lost. The read returns the old contents and the new bit remains set.
- R6: Writes to event registers and to summary registers have no effect. Enable registers read back what was written, limited to their width: 8 bits per event enable, 4 bits per summary enable, one bit per port for port enables, and only bit 3 for general control.
- R7: Port summary bit 0 is the OR of transmit events ANDed with transmit enables. Bit 1 is the same for receive. Bit 2 follows `onesec_irq` and bit 3 follows `ext_irq`.
- R8: Global summary bit p is 1 exactly when port p's summary ANDed with its summary enables is non-zero.
- R9: With general-control bit 3 set, `irq_n` goes low one cycle after any global summary bit is present together with its port enable, and goes high one cycle after none is.
- R10: With general-control bit 3 clear, `irq_n` stays high whatever the summaries hold.
- R11: Reads of unused offsets and of port numbers at or above NUM_PORTS return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_stat | input | NUM_PORTS*LVL1_W | Raw transmit status, port p at bits p*LVL1_W upward |
| rx_stat | input | NUM_PORTS*LVL1_W | Raw receive status, same packing |
| onesec_irq | input | NUM_PORTS | One-second interrupt level per port |
| ext_irq | input | NUM_PORTS | External interrupt level per port |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The checker watches several properties on every cycle. The reset state must hold. A single-event bit may only rise after its raw input was high. Any event must be present in its register on the next cycle, even under a clearing read. A read with no concurrent event must empty the register. The pin must follow the gated summary with one cycle of delay and stay high while pin-enable is clear. Other properties need the bench's stimulus and arithmetic expected values, because they concern what software sees through the register port: the per-bit single/dual configuration across every position of both sides, read-back widths, ignored writes, unused addresses, and the full combination of enables, level inputs and pin gating.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned SUM_W    = 4;

    // address fields
    localparam int unsigned GLOB_BIT = 7;
    localparam int unsigned PORT_MSB = 6;
    localparam int unsigned PORT_LSB = 3;

    // per-port register offsets
    localparam logic [2:0] OFS_TX_EVT = 3'd0;
    localparam logic [2:0] OFS_RX_EVT = 3'd1;
    localparam logic [2:0] OFS_TX_EN  = 3'd2;
    localparam logic [2:0] OFS_RX_EN  = 3'd3;
    localparam logic [2:0] OFS_SUM    = 3'd4;
    localparam logic [2:0] OFS_SUM_EN = 3'd5;

    // global register offsets
    localparam logic [2:0] GOFS_SUM   = 3'd0;
    localparam logic [2:0] GOFS_EN    = 3'd1;
    localparam logic [2:0] GOFS_CTRL  = 3'd2;

    localparam int unsigned PIN_EN_BIT = 3;

    // summary bit positions
    localparam int unsigned SUM_TX  = 0;
    localparam int unsigned SUM_RX  = 1;
    localparam int unsigned SUM_SEC = 2;
    localparam int unsigned SUM_EXT = 3;

    typedef enum logic {
        PIN_QUIET  = 1'b0,
        PIN_RAISED = 1'b1
    } pin_state_e;

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     DUAL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    input  logic             rd_clr,
    output logic [WIDTH-1:0] lat,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] prev_q;

    // rising edges always count; falling edges only where dual-event
    always_comb begin
        evt = (raw & ~prev_q) | (~raw & prev_q & DUAL_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            lat    <= '0;
        end else begin
            prev_q <= raw;
            // a new event wins over a clearing read
            lat    <= (rd_clr ? '0 : lat) | evt;
        end
    end

endmodule

// File: rtl/irq_port_node.sv
module irq_port_node
    import irq_tree_pkg::*;
#(
    parameter int unsigned          LVL1_W  = 8,
    parameter logic [LVL1_W-1:0]    TX_DUAL = '0,
    parameter logic [LVL1_W-1:0]    RX_DUAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL1_W-1:0] tx_raw,
    input  logic [LVL1_W-1:0] rx_raw,
    input  logic              onesec_irq,
    input  logic              ext_irq,
    input  logic              sel_port,
    input  logic              bus_wr,
    input  logic [2:0]        ofs,
    input  logic [LVL1_W-1:0] wdata,
    output logic [LVL1_W-1:0] tx_lat,
    output logic [LVL1_W-1:0] rx_lat,
    output logic [LVL1_W-1:0] tx_evt,
    output logic [LVL1_W-1:0] rx_evt,
    output logic [LVL1_W-1:0] tx_en,
    output logic [LVL1_W-1:0] rx_en,
    output logic [SUM_W-1:0]  sum,
    output logic [SUM_W-1:0]  sum_en,
    output logic              port_req
);

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = sel_port & bus_wr;
    assign rd_hit = sel_port & ~bus_wr;

    irq_edge_latch #(
        .WIDTH     (LVL1_W),
        .DUAL_MASK (TX_DUAL)
    ) tx_latch_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (tx_raw),
        .rd_clr (rd_hit && ofs == OFS_TX_EVT),
        .lat    (tx_lat),
        .evt    (tx_evt)
    );

    irq_edge_latch #(
        .WIDTH     (LVL1_W),
        .DUAL_MASK (RX_DUAL)
    ) rx_latch_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (rx_raw),
        .rd_clr (rd_hit && ofs == OFS_RX_EVT),
        .lat    (rx_lat),
        .evt    (rx_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en  <= '0;
            rx_en  <= '0;
            sum_en <= '0;
        end else if (wr_hit) begin
            if (ofs == OFS_TX_EN)  tx_en  <= wdata;
            if (ofs == OFS_RX_EN)  rx_en  <= wdata;
            if (ofs == OFS_SUM_EN) sum_en <= wdata[SUM_W-1:0];
        end
    end

    always_comb begin
        sum          = '0;
        sum[SUM_TX]  = |(tx_lat & tx_en);
        sum[SUM_RX]  = |(rx_lat & rx_en);
        sum[SUM_SEC] = onesec_irq;
        sum[SUM_EXT] = ext_irq;
        port_req     = |(sum & sum_en);
    end

endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
    import irq_tree_pkg::*;
#(
    parameter int unsigned          NUM_PORTS    = 4,
    parameter int unsigned          LVL1_W       = 8,
    parameter logic [LVL1_W-1:0]    TX_DUAL_MASK = 8'h0F,
    parameter logic [LVL1_W-1:0]    RX_DUAL_MASK = 8'h8F
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS*LVL1_W-1:0]   tx_stat,
    input  logic [NUM_PORTS*LVL1_W-1:0]   rx_stat,
    input  logic [NUM_PORTS-1:0]          onesec_irq,
    input  logic [NUM_PORTS-1:0]          ext_irq,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          irq_n
);

    localparam int unsigned PFIELD_W = PORT_MSB - PORT_LSB + 1;

    logic [NUM_PORTS-1:0][LVL1_W-1:0] tx_lat_a, rx_lat_a, tx_en_a, rx_en_a;
    logic [NUM_PORTS-1:0][SUM_W-1:0]  sum_a, sum_en_a;
    logic [NUM_PORTS*LVL1_W-1:0]      tx_lat_all, rx_lat_all, tx_evt_all, rx_evt_all;
    logic [NUM_PORTS-1:0]             glob_sum;
    logic [NUM_PORTS-1:0]             port_en_q;
    logic                             pin_en_q;
    logic                             pin_gate;
    logic [2:0]                       ofs;
    logic                             glob_sel;
    logic [PFIELD_W-1:0]              port_field;
    logic [DATA_W-1:0]                rd_mux;
    pin_state_e                       pin_q, pin_d;

    assign ofs        = bus_addr[2:0];
    assign glob_sel   = bus_addr[GLOB_BIT];
    assign port_field = bus_addr[PORT_MSB:PORT_LSB];

    // ---------------- per-port first and second tiers ----------------
    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        logic sel_p;
        assign sel_p = bus_sel & ~glob_sel & (port_field == PFIELD_W'(gp));

        irq_port_node #(
            .LVL1_W  (LVL1_W),
            .TX_DUAL (TX_DUAL_MASK),
            .RX_DUAL (RX_DUAL_MASK)
        ) node_i (
            .clk        (clk),
            .rst        (rst),
            .tx_raw     (tx_stat[gp*LVL1_W +: LVL1_W]),
            .rx_raw     (rx_stat[gp*LVL1_W +: LVL1_W]),
            .onesec_irq (onesec_irq[gp]),
            .ext_irq    (ext_irq[gp]),
            .sel_port   (sel_p),
            .bus_wr     (bus_wr),
            .ofs        (ofs),
            .wdata      (bus_wdata[LVL1_W-1:0]),
            .tx_lat     (tx_lat_a[gp]),
            .rx_lat     (rx_lat_a[gp]),
            .tx_evt     (tx_evt_all[gp*LVL1_W +: LVL1_W]),
            .rx_evt     (rx_evt_all[gp*LVL1_W +: LVL1_W]),
            .tx_en      (tx_en_a[gp]),
            .rx_en      (rx_en_a[gp]),
            .sum        (sum_a[gp]),
            .sum_en     (sum_en_a[gp]),
            .port_req   (glob_sum[gp])
        );

        assign tx_lat_all[gp*LVL1_W +: LVL1_W] = tx_lat_a[gp];
        assign rx_lat_all[gp*LVL1_W +: LVL1_W] = rx_lat_a[gp];
    end

    // ---------------- third tier and general control ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            port_en_q <= '0;
            pin_en_q  <= 1'b0;
        end else if (bus_sel && bus_wr && glob_sel) begin
            if (ofs == GOFS_EN)   port_en_q <= bus_wdata[NUM_PORTS-1:0];
            if (ofs == GOFS_CTRL) pin_en_q  <= bus_wdata[PIN_EN_BIT];
        end
    end

    assign pin_gate = (|(glob_sum & port_en_q)) & pin_en_q;

    // ---------------- pin state machine ----------------
    always_comb begin
        pin_d = pin_q;
        unique case (pin_q)
            PIN_QUIET:  if (pin_gate)  pin_d = PIN_RAISED;
            PIN_RAISED: if (!pin_gate) pin_d = PIN_QUIET;
            default:                   pin_d = PIN_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= PIN_QUIET;
        else     pin_q <= pin_d;
    end

    always_comb begin
        irq_n = (pin_q != PIN_RAISED);
    end

    // ---------------- read path ----------------
    always_comb begin
        rd_mux = '0;
        if (glob_sel) begin
            unique case (ofs)
                GOFS_SUM:  rd_mux = DATA_W'(glob_sum);
                GOFS_EN:   rd_mux = DATA_W'(port_en_q);
                GOFS_CTRL: rd_mux[PIN_EN_BIT] = pin_en_q;
                default:   rd_mux = '0;
            endcase
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_field == PFIELD_W'(p)) begin
                    unique case (ofs)
                        OFS_TX_EVT: rd_mux = DATA_W'(tx_lat_a[p]);
                        OFS_RX_EVT: rd_mux = DATA_W'(rx_lat_a[p]);
                        OFS_TX_EN:  rd_mux = DATA_W'(tx_en_a[p]);
                        OFS_RX_EN:  rd_mux = DATA_W'(rx_en_a[p]);
                        OFS_SUM:    rd_mux = DATA_W'(sum_a[p]);
                        OFS_SUM_EN: rd_mux = DATA_W'(sum_en_a[p]);
                        default:    rd_mux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
    import irq_tree_pkg::*;
#(
    parameter int unsigned          NUM_PORTS    = 4,
    parameter int unsigned          LVL1_W       = 8,
    parameter logic [LVL1_W-1:0]    TX_DUAL_MASK = 8'h0F,
    parameter logic [LVL1_W-1:0]    RX_DUAL_MASK = 8'h8F
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_PORTS*LVL1_W-1:0] tx_stat,
    input logic [NUM_PORTS*LVL1_W-1:0] rx_stat,
    input logic [NUM_PORTS*LVL1_W-1:0] tx_lat_all,
    input logic [NUM_PORTS*LVL1_W-1:0] rx_lat_all,
    input logic [NUM_PORTS*LVL1_W-1:0] tx_evt_all,
    input logic [NUM_PORTS*LVL1_W-1:0] rx_evt_all,
    input logic                        pin_gate,
    input logic                        pin_en_q,
    input logic                        irq_n
);

    localparam int unsigned PFIELD_W = PORT_MSB - PORT_LSB + 1;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq_n && bus_rdata == '0 && tx_lat_all == '0 && rx_lat_all == '0)); // R1

    for (genvar gi = 0; gi < NUM_PORTS*LVL1_W; gi++) begin : g_bit
        if (!TX_DUAL_MASK[gi % LVL1_W]) begin : g_tx_single
            AST_TX_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
                $rose(tx_lat_all[gi]) |-> $past(tx_stat[gi])); // R2
        end
        if (!RX_DUAL_MASK[gi % LVL1_W]) begin : g_rx_single
            AST_RX_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
                $rose(rx_lat_all[gi]) |-> $past(rx_stat[gi])); // R2
        end
    end

    AST_TX_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (tx_evt_all != '0) |=> ((tx_lat_all & $past(tx_evt_all)) == $past(tx_evt_all))); // R5
    AST_RX_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rx_evt_all != '0) |=> ((rx_lat_all & $past(rx_evt_all)) == $past(rx_evt_all))); // R5

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        AST_TX_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_wr && !bus_addr[GLOB_BIT]
             && bus_addr[PORT_MSB:PORT_LSB] == PFIELD_W'(gp) && bus_addr[2:0] == OFS_TX_EVT
             && tx_evt_all[gp*LVL1_W +: LVL1_W] == '0)
            |=> (tx_lat_all[gp*LVL1_W +: LVL1_W] == '0)); // R4
        AST_RX_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_wr && !bus_addr[GLOB_BIT]
             && bus_addr[PORT_MSB:PORT_LSB] == PFIELD_W'(gp) && bus_addr[2:0] == OFS_RX_EVT
             && rx_evt_all[gp*LVL1_W +: LVL1_W] == '0)
            |=> (rx_lat_all[gp*LVL1_W +: LVL1_W] == '0)); // R4
    end

    AST_PIN_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        pin_gate |=> !irq_n); // R9
    AST_PIN_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !pin_gate |=> irq_n); // R9
    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (rst)
        !pin_en_q |=> irq_n); // R10

endmodule

bind irq_tree_ctrl irq_tree_chk #(
    .NUM_PORTS    (NUM_PORTS),
    .LVL1_W       (LVL1_W),
    .TX_DUAL_MASK (TX_DUAL_MASK),
    .RX_DUAL_MASK (RX_DUAL_MASK)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .tx_stat    (tx_stat),
    .rx_stat    (rx_stat),
    .tx_lat_all (tx_lat_all),
    .rx_lat_all (rx_lat_all),
    .tx_evt_all (tx_evt_all),
    .rx_evt_all (rx_evt_all),
    .pin_gate   (pin_gate),
    .pin_en_q   (pin_en_q),
    .irq_n      (irq_n)
);

// File: tb/irq_tree_ctrl_tb_top.sv
module irq_tree_ctrl_tb_top;

    localparam int unsigned NP     = 2;
    localparam int unsigned W      = 8;
    localparam logic [7:0]  TXDUAL = 8'h0F;
    localparam logic [7:0]  RXDUAL = 8'h8F;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP*W-1:0] tx_stat = '0;
    logic [NP*W-1:0] rx_stat = '0;
    logic [NP-1:0]   onesec_irq = '0;
    logic [NP-1:0]   ext_irq = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            irq_n;

    int vectors = 0;
    int fails   = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_tree_ctrl #(
        .NUM_PORTS    (NP),
        .LVL1_W       (W),
        .TX_DUAL_MASK (TXDUAL),
        .RX_DUAL_MASK (RXDUAL)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .tx_stat    (tx_stat),
        .rx_stat    (rx_stat),
        .onesec_irq (onesec_irq),
        .ext_irq    (ext_irq),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_n      (irq_n)
    );

    function automatic logic [7:0] paddr(input int p, input int o);
        return {1'b0, 4'(p), 3'(o)};
    endfunction

    function automatic logic [7:0] gaddr(input int o);
        return {1'b1, 4'd0, 3'(o)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] dat);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = dat;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 rdata", bus_rdata, 8'h00);
        rd(paddr(0, 0), d); check("R1 tx events", d, 8'h00);
        rd(paddr(1, 2), d); check("R1 tx enables", d, 8'h00);
        rd(paddr(0, 5), d); check("R1 sum enables", d, 8'h00);
        rd(gaddr(1), d);    check("R1 port enables", d, 8'h00);
        rd(gaddr(2), d);    check("R1 control", d, 8'h00);
        rd(gaddr(0), d);    check("R1 global summary", d, 8'h00);

        // R2 / R3 / R4: sweep every bit of both sides on both ports
        for (int p = 0; p < NP; p++) begin
            for (int side = 0; side < 2; side++) begin
                for (int b = 0; b < W; b++) begin
                    logic dual;
                    logic [7:0] bitv;
                    dual = side ? RXDUAL[b] : TXDUAL[b];
                    bitv = 8'(1 << b);
                    if (side == 0) tx_stat[p*W+b] = 1'b1; else rx_stat[p*W+b] = 1'b1;
                    rd(paddr(p, side), d);
                    check(dual ? "R3 rise" : "R2 rise", d, bitv);
                    rd(paddr(p, side), d);
                    check("R4 cleared", d, 8'h00);
                    if (side == 0) tx_stat[p*W+b] = 1'b0; else rx_stat[p*W+b] = 1'b0;
                    rd(paddr(p, side), d);
                    check(dual ? "R3 fall" : "R2 fall ignored", d, dual ? bitv : 8'h00);
                    rd(paddr(p, side), d);
                    check("R4 cleared after fall", d, 8'h00);
                end
            end
        end

        // R5: event in the same cycle as the clearing read
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = paddr(0, 0);
        tx_stat[5] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0;
        check("R5 old contents", bus_rdata, 8'h00);
        rd(paddr(0, 0), d); check("R5 event kept", d, 8'h20);
        tx_stat[5] = 1'b0;

        // R6: ignored writes and enable read-back
        tx_stat[6] = 1'b1;
        wr(paddr(0, 0), 8'h00);
        wr(paddr(0, 4), 8'hFF);
        wr(gaddr(0), 8'hFF);
        rd(paddr(0, 4), d); check("R6 summary write ignored", d, 8'h00);
        rd(gaddr(0), d);    check("R6 global write ignored", d, 8'h00);
        rd(paddr(0, 0), d); check("R6 event write ignored", d, 8'h40);
        tx_stat[6] = 1'b0;
        wr(paddr(0, 2), 8'hA5); wr(paddr(0, 3), 8'h5A); wr(paddr(1, 3), 8'h3C);
        wr(paddr(0, 5), 8'hFF); wr(gaddr(1), 8'hFF); wr(gaddr(2), 8'hFF);
        rd(paddr(0, 2), d); check("R6 tx enable", d, 8'hA5);
        rd(paddr(0, 3), d); check("R6 rx enable port isolation", d, 8'h5A);
        rd(paddr(1, 3), d); check("R6 rx enable port1", d, 8'h3C);
        rd(paddr(0, 5), d); check("R6 sum enable width", d, 8'h0F);
        rd(gaddr(1), d);    check("R6 port enable width", d, 8'h03);
        rd(gaddr(2), d);    check("R6 control width", d, 8'h08);

        // R11: unused addresses
        rd(paddr(0, 6), d); check("R11 unused offset", d, 8'h00);
        rd(paddr(5, 2), d); check("R11 absent port", d, 8'h00);
        rd(gaddr(3), d);    check("R11 unused global", d, 8'h00);

        // restore enables
        wr(paddr(0, 3), 8'h00); wr(paddr(1, 3), 8'h00);

        // R7..R10 sweep: port0 tx bit4 latched, port1 rx bit7 latched and enabled
        tx_stat[4]  = 1'b1;
        rx_stat[15] = 1'b1;
        wr(paddr(1, 3), 8'h80);
        wr(paddr(1, 5), 8'h02);
        for (int ti = 0; ti < 3; ti++) begin
            for (int s = 0; s < 2; s++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int se = 0; se < 16; se++) begin
                        for (int pe = 0; pe < 4; pe++) begin
                            for (int g = 0; g < 2; g++) begin
                                logic [7:0] ten, psum, gsum;
                                logic pin_low;
                                ten = (ti == 0) ? 8'h00 : (ti == 1) ? 8'h10 : 8'hEF;
                                onesec_irq[0] = s[0];
                                ext_irq[0]    = e[0];
                                wr(paddr(0, 2), ten);
                                wr(paddr(0, 5), 8'(se));
                                wr(gaddr(1), 8'(pe));
                                wr(gaddr(2), g ? 8'h08 : 8'h00);
                                psum = {4'd0, e[0], s[0], 1'b0, |(ten & 8'h10)};
                                gsum = {6'd0, 1'b1, |(psum & 8'(se))};
                                pin_low = (|(gsum & 8'(pe))) && (g == 1);
                                rd(paddr(0, 4), d); check("R7 port summary", d, psum);
                                rd(gaddr(0), d);    check("R8 global summary", d, gsum);
                                check(g ? "R9 pin" : "R10 pin masked",
                                      {7'd0, irq_n}, {7'd0, !pin_low});
                            end
                        end
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule